// File: doc/BRIEF.md
# Code Upload Receiver with Payload Signature

This block is the receive end of a bulk code transfer that arrives over a two-wire open-collector serial bus. The bus has a clock line and a data line. A start pulse begins the transfer. The block then runs a short line handshake: it holds the clock line low, leaves the data line released, waits until the sender pulls the data line low, and then lets go of the clock line. After that it accepts a fixed-size block of bytes from an abstract byte-receive interface (a valid strobe with a data byte). The bit-level decoding of each byte happens outside this block.

Each accepted byte is written in arrival order into an internal buffer that can be inferred as block RAM. While the bytes arrive, the block folds only a leading window of them into an XOR signature. The last bytes of the block are stored but left out of the signature. Once the final byte has arrived, the block raises a done flag. It reports which known payload variant the signature matches, or raises a mismatch flag when the signature matches neither. The buffer can be read at any time through a synchronous read port.

Top module: `upload_rx`

## Requirements
- R1: While reset is high, and in the cycle after it, the clock-line pull, the data-line pull, busy, done, mismatch and the variant code (2'd0) are all zero.
- R2: A start pulse seen while the block is idle or done asserts the clock-line pull and busy on the next clock edge and clears done, mismatch and the variant code. The data-line pull output stays 0 at all times.
- R3: The clock line stays pulled low until the data-line input, after two synchronizer flops, reads low. If the data input goes low before edge n, the clock-line pull drops after edge n+2.
- R4: After the clock line is released, exactly BLOCK_LEN (256) strobed bytes are accepted and stored at addresses 0 upward in arrival order. A read address presented before an edge returns its byte after that edge.
- R5: Byte strobes that arrive while the block is idle, done or in the handshake are ignored. They are not stored and do not count toward the block.
- R6: The signature is the XOR of the first SIG_LEN (237) accepted bytes only. Bytes 238 to 256 have no effect on it.
- R7: On the edge that accepts the last byte, done rises and busy falls. The variant code becomes 2'd1 for signature 0x91 or 2'd2 for signature 0x5B.
- R8: Any other signature gives variant code 2'd0 with mismatch high. Mismatch is only ever high together with done.
- R9: Done, the variant code and mismatch hold until the next start pulse. A start pulse during the handshake or the receive phase is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (single-cycle pulse) |
| data_line_i | input | 1 | Sensed level of the data line (asynchronous) |
| clk_pull_o | output | 1 | 1 = pull clock line low |
| data_pull_o | output | 1 | 1 = pull data line low (always released) |
| byte_valid_i | input | 1 | Byte strobe from the byte receiver |
| byte_data_i | input | 8 | Received byte |
| rd_addr_i | input | ADDR_W (8) | Buffer read address |
| rd_data_o | output | 8 | Buffer read data, one cycle latency |
| busy_o | output | 1 | Handshake or receive in progress |
| done_o | output | 1 | Block complete |
| variant_o | output | 2 | 0 none, 1 first variant, 2 second variant |
| mismatch_o | output | 1 | Signature matched no known variant |

## Verification
The bench builds the block with its full default values: a 256-byte block, a 237-byte signature window and the two signature constants. This lets it reach the real boundary between the signature window and the stored tail, and the last-byte address that wraps the 8-bit counter. The payloads are built so that byte 237 forces the chosen signature while the tail bytes are nonzero. A tail that leaked into the signature would therefore change the reported variant. Stray strobes and start pulses are placed in the idle, handshake and receive phases, and the data line is driven low both before and after start.

// File: rtl/upload_pkg.sv
package upload_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_HANDSHAKE = 2'd1,
    ST_RECEIVE   = 2'd2,
    ST_DONE      = 2'd3
  } upl_state_t;

  localparam logic [1:0] VARIANT_NONE = 2'd0;
  localparam logic [1:0] VARIANT_A    = 2'd1;
  localparam logic [1:0] VARIANT_B    = 2'd2;

  function automatic logic [1:0] classify_sig(input logic [7:0] sig,
                                              input logic [7:0] sig_a,
                                              input logic [7:0] sig_b);
    if (sig == sig_a)      return VARIANT_A;
    else if (sig == sig_b) return VARIANT_B;
    else                   return VARIANT_NONE;
  endfunction

endpackage

// File: rtl/upload_line_sync.sv
module upload_line_sync #(
  parameter int         WIDTH   = 1,
  parameter logic [0:0] RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_o <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end

endmodule

// File: rtl/upload_buffer.sv
module upload_buffer #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Single write port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/upload_sig_accum.sv
module upload_sig_accum #(
  parameter int SIG_LEN = 237,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [7:0]       sig_o,
  output logic [7:0]       sig_next_o
);

  logic in_window;

  assign in_window  = (32'(idx_i) < 32'(SIG_LEN));
  assign sig_next_o = (take_i && in_window) ? (sig_o ^ byte_i) : sig_o;

  always_ff @(posedge clk) begin
    if (rst || clr_i) sig_o <= 8'h00;
    else              sig_o <= sig_next_o;
  end

  // R6: bytes past the window leave the signature untouched
  p_tail_excluded_r6: assert property (@(posedge clk) disable iff (rst)
    (take_i && !clr_i && (32'(idx_i) >= 32'(SIG_LEN))) |=> (sig_o == $past(sig_o)));

endmodule

// File: rtl/upload_rx.sv
module upload_rx
  import upload_pkg::*;
#(
  parameter int         BLOCK_LEN = 256,
  parameter int         SIG_LEN   = 237,
  parameter logic [7:0] SIG_A     = 8'h91,
  parameter logic [7:0] SIG_B     = 8'h5B,
  parameter int         ADDR_W    = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              data_line_i,
  output logic              clk_pull_o,
  output logic              data_pull_o,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        variant_o,
  output logic              mismatch_o
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(BLOCK_LEN - 1);

  upl_state_t        state_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              data_s;
  logic              launch;
  logic              take;
  logic [7:0]        sig_q;
  logic [7:0]        sig_next;
  logic [1:0]        verdict;

  upload_line_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (data_line_i),
    .sync_o  (data_s)
  );

  assign launch = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign take   = byte_valid_i && (state_q == ST_RECEIVE);

  upload_sig_accum #(.SIG_LEN(SIG_LEN), .IDX_W(ADDR_W)) u_sig (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (launch),
    .take_i     (take),
    .idx_i      (cnt_q),
    .byte_i     (byte_data_i),
    .sig_o      (sig_q),
    .sig_next_o (sig_next)
  );

  upload_buffer #(.DEPTH(BLOCK_LEN), .ADDR_W(ADDR_W), .DATA_W(8)) u_buf (
    .clk     (clk),
    .we_i    (take),
    .waddr_i (cnt_q),
    .wdata_i (byte_data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign verdict     = classify_sig(sig_next, SIG_A, SIG_B);
  assign data_pull_o = 1'b0;  // data line is left released by this side

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      clk_pull_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      variant_o  <= VARIANT_NONE;
      mismatch_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            state_q    <= ST_HANDSHAKE;
            cnt_q      <= '0;
            clk_pull_o <= 1'b1;
            busy_o     <= 1'b1;
            done_o     <= 1'b0;
            variant_o  <= VARIANT_NONE;
            mismatch_o <= 1'b0;
          end
        end
        ST_HANDSHAKE: begin
          if (!data_s) begin
            state_q    <= ST_RECEIVE;
            clk_pull_o <= 1'b0;
          end
        end
        ST_RECEIVE: begin
          if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
              state_q    <= ST_DONE;
              busy_o     <= 1'b0;
              done_o     <= 1'b1;
              variant_o  <= verdict;
              mismatch_o <= (verdict == VARIANT_NONE);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted start pulls the clock line and enters busy
  p_start_pulls_clock_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (clk_pull_o && busy_o && !done_o));

  // R3: the clock line is only let go after the synchronized data line was low
  p_release_after_low_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_pull_o) |-> !$past(data_s));

  // R7: a matching variant and the mismatch flag exclude each other
  p_variant_consistent_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mismatch_o == (variant_o == VARIANT_NONE)));

  // R8: mismatch never appears without done
  p_mismatch_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    mismatch_o |-> done_o);

  // R9: completion is held until a new start
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(variant_o) && $stable(mismatch_o)));

endmodule

// File: tb/upload_rx_tb_top.sv
module upload_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BLK        = 256;
  localparam int SIG        = 237;
  localparam int AW         = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          host_low = 1'b0;
  logic          data_line_i;
  logic          clk_pull_o, data_pull_o;
  logic          byte_valid_i = 1'b0;
  logic [7:0]    byte_data_i = 8'h00;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    rd_data_o;
  logic          busy_o, done_o, mismatch_o;
  logic [1:0]    variant_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  assign data_line_i = !(host_low || data_pull_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  upload_rx #(.BLOCK_LEN(BLK), .SIG_LEN(SIG), .SIG_A(8'h91), .SIG_B(8'h5B), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .data_line_i(data_line_i),
    .clk_pull_o(clk_pull_o), .data_pull_o(data_pull_o),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o), .variant_o(variant_o), .mismatch_o(mismatch_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int         m_phase = 0;  // 0 idle, 1 handshake, 2 receive, 3 done
  int         m_cnt = 0;
  logic [7:0] m_sig = 0;
  logic [1:0] m_var = 0;
  bit         m_done = 0, m_mis = 0;
  bit         m_s1 = 1, m_s2 = 1;
  logic [7:0] m_mem [BLK];
  logic [7:0] pay [BLK];

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_sig = 0; m_var = 0; m_done = 0; m_mis = 0;
      m_s1 = 1; m_s2 = 1;
    end else begin
      case (m_phase)
        0, 3: if (start_i) begin
          m_phase = 1; m_cnt = 0; m_sig = 0; m_var = 0; m_done = 0; m_mis = 0;
        end
        1: if (!m_s2) m_phase = 2;
        2: if (byte_valid_i) begin
          m_mem[m_cnt] = byte_data_i;
          if (m_cnt < SIG) m_sig = m_sig ^ byte_data_i;
          m_cnt++;
          if (m_cnt == BLK) begin
            m_phase = 3; m_done = 1;
            m_var = (m_sig == 8'h91) ? 2'd1 : (m_sig == 8'h5B) ? 2'd2 : 2'd0;
            m_mis = (m_var == 2'd0);
          end
        end
        default: ;
      endcase
      m_s2 = m_s1; m_s1 = data_line_i;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 data pull", 32'(data_pull_o), 0);
      chk("R3 clock pull", 32'(clk_pull_o), 32'(m_phase == 1));
      chk("R2 busy", 32'(busy_o), 32'(m_phase == 1 || m_phase == 2));
      chk("R7 done", 32'(done_o), 32'(m_done));
      chk("R7 variant", 32'(variant_o), 32'(m_var));
      chk("R8 mismatch", 32'(mismatch_o), 32'(m_mis));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic build(input logic [7:0] target, input logic [7:0] seed);
    logic [7:0] x = 8'h00;
    for (int i = 0; i < SIG - 1; i++) begin
      pay[i] = 8'((i * 29 + 7)) ^ seed;
      x ^= pay[i];
    end
    pay[SIG-1] = x ^ target;
    for (int i = SIG; i < BLK; i++) pay[i] = 8'(i) ^ seed ^ 8'hA5;
    pay[SIG] = 8'hCA;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send_block(input bit stray_start);
    for (int i = 0; i < BLK; i++) begin
      byte_valid_i = 1'b1; byte_data_i = pay[i];
      if (stray_start && i == 100) start_i = 1'b1;  // R9: ignored mid-receive
      @(negedge clk);
      start_i = 1'b0;
      if (i % 3 == 1) begin byte_valid_i = 1'b0; byte_data_i = 8'hEE; @(negedge clk); end
    end
    byte_valid_i = 1'b0;
  endtask

  task automatic readback(input string tag);
    int bad = 0;
    for (int a = 0; a < BLK; a++) begin
      rd_addr_i = AW'(a); @(negedge clk);
      if (rd_data_o !== pay[a]) bad++;
      tests++;
      if (rd_data_o !== pay[a]) begin
        fails++;
        $display("FAIL R4 %s addr=%0d actual=%0h expected=%0h", tag, a, rd_data_o, pay[a]);
      end
    end
  endtask

  task automatic run(input logic [7:0] target, input logic [7:0] seed,
                     input bit early_low, input logic [1:0] exp_var);
    build(target, seed);
    host_low = early_low;
    pulse_start();
    chk("R2 clock pulled after start", 32'(clk_pull_o), 1);
    if (!early_low) begin
      // R5: strobes during the handshake are not taken
      byte_valid_i = 1'b1; byte_data_i = 8'h77;
      repeat (6) @(negedge clk);
      byte_valid_i = 1'b0;
      chk("R3 clock held while data high", 32'(clk_pull_o), 1);
      host_low = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R3 still held two edges after data low", 32'(clk_pull_o), 1);
      @(negedge clk);
      chk("R3 released three edges after data low", 32'(clk_pull_o), 0);
    end else begin
      repeat (3) @(negedge clk);
      chk("R3 released with data already low", 32'(clk_pull_o), 0);
    end
    host_low = 1'b0;
    send_block(1'b1);
    chk("R7 done after last byte", 32'(done_o), 1);
    chk("R7 variant code", 32'(variant_o), 32'(exp_var));
    chk("R8 mismatch flag", 32'(mismatch_o), 32'(exp_var == 2'd0));
    // R5: strobes after completion are ignored
    byte_valid_i = 1'b1; byte_data_i = 8'h00; @(negedge clk); byte_valid_i = 1'b0;
    readback("block");
    chk("R9 done held", 32'(done_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 clock pull in reset", 32'(clk_pull_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 clock pull", 32'(clk_pull_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 variant", 32'(variant_o), 0);
    chk("R1 mismatch", 32'(mismatch_o), 0);
    // R5: strobes while idle are ignored
    byte_valid_i = 1'b1; byte_data_i = 8'h55;
    repeat (4) @(negedge clk);
    byte_valid_i = 1'b0;
    chk("R5 idle strobes ignored", 32'(busy_o), 0);
    run(8'h91, 8'h13, 1'b0, 2'd1);   // R7 first variant
    run(8'h5B, 8'h6C, 1'b1, 2'd2);   // R6 tail byte 0xCA excluded
    run(8'h3C, 8'h21, 1'b0, 2'd0);   // R8 no match
    run(8'h00, 8'h91, 1'b1, 2'd0);   // R6/R8 window XOR zero
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule